// File: doc/BRIEF.md
# Key-Guarded Control Register Window

This block is a small bank of control registers reached over a 32-bit register bus with address, write data, write strobe, read strobe and read data. The registers in one address window, 0x8000 to 0x9FFF, are guarded against stray writes. Software opens the window by writing one fixed 32-bit key into a first unlock register and then a second fixed key into a second unlock register. Writing any other value to either unlock register closes the window again. The canonical way to close it is to write all ones to both.

Inside the window sit a pad-enable word, a reference-clock select word and a few general scratch words. The pad-enable bit, the clock output enable and the two-bit clock source leave the block as ports. A lock flag shows the current guard state. The unlock registers sit outside the guarded window and always accept writes. Reads are never blocked.

Top module: `kick_lock_regbank`

## Requirements
- R1: After a synchronous active-low reset the window is locked (`part_locked`=1). Every guarded register reads 0, `pad_en`, `refclk_oe`, `refclk_src` and `bus_rdata` are 0.
- R2: The window opens on this sequence: 0x68EF3490 written to the first unlock register at 0x1008, then 0xD172BC5A written to the second unlock register at 0x100C. `part_locked` drops on the clock edge that takes the second write.
- R3: The window stays locked in each of these cases: a wrong value in either unlock register, the second key written before the first, or any other write to an unlock register between the two keys.
- R4: While open, a write to 0x1008 of any value other than 0x68EF3490, or a write to 0x100C of any value other than 0xD172BC5A, locks the window again. This includes 0xFFFFFFFF. Rewriting the matching key leaves the window open.
- R5: While locked, writes to addresses 0x8000..0x9FFF are dropped with no error. Register contents and output ports keep their values, and reads still return the current contents.
- R6: The pad register at 0x8100 is a full 32-bit register. `pad_en` follows its bit 24 and changes on the edge that takes an accepted write.
- R7: Of the clock-select register at 0x8200 only bit 8 (output enable, shown on `refclk_oe`) and bits [1:0] (source, shown on `refclk_src`) take write data. All other bits keep their value of 0. The outputs change on the edge that takes the write.
- R8: Four 32-bit scratch registers at 0x8300, 0x8304, 0x8308 and 0x830C can be written when the window is open and read back.
- R9: Reading either unlock register returns 1 in bit 0 when the window is open and 0 otherwise. A correct first key alone still reads 0.
- R10: `bus_rdata` loads on the edge where `bus_re` is high and holds otherwise. Addresses with no register behind them read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_en | output | 1 | Clock-buffer pad enable |
| refclk_oe | output | 1 | Reference clock output enable |
| refclk_src | output | 2 | Reference clock source select |
| part_locked | output | 1 | 1 while the guarded window is locked |

## Verification
The bench targets the key sequence at its edges:
- Single-nibble corruptions of each key, which a design comparing too few bits would accept.
- The second key arriving first or after an interleaved bad write, which a design without a middle state would wrongly accept.
- Rewriting the matching key while open, which a design that relocks on any kick write would get wrong.

It sweeps every combination of source, enable and stray filler bits through the clock-select register. That catches a wrong write mask, which would leak filler bits into readback or leave the outputs stuck. It also checks that locked writes change neither contents nor ports, and that a relock takes effect at once.

// File: rtl/kick_lock_pkg.sv
// Package: shared constants and types for the key-guarded register window.
// Assumes byte addressing with word-aligned accesses.
package kick_lock_pkg;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned NUM_SCRATCH = 4;

    localparam logic [ADDR_W-1:0] UNLK0_ADDR = 16'h1008;
    localparam logic [ADDR_W-1:0] UNLK1_ADDR = 16'h100C;
    localparam logic [ADDR_W-1:0] WIN_LO     = 16'h8000;
    localparam logic [ADDR_W-1:0] WIN_HI     = 16'h9FFF;
    localparam logic [ADDR_W-1:0] PAD_ADDR   = 16'h8100;
    localparam logic [ADDR_W-1:0] CSEL_ADDR  = 16'h8200;
    localparam logic [ADDR_W-1:0] SCR_BASE   = 16'h8300;

    localparam logic [DATA_W-1:0] KEY_A = 32'h68EF3490;
    localparam logic [DATA_W-1:0] KEY_B = 32'hD172BC5A;

    localparam int unsigned PAD_BIT  = 24;
    localparam int unsigned OE_BIT   = 8;
    localparam int unsigned SRC_W    = 2;
    localparam logic [DATA_W-1:0] CSEL_MASK = 32'h0000_0103;

    typedef enum logic [1:0] {
        GUARD_SHUT  = 2'd0,
        GUARD_HALF  = 2'd1,
        GUARD_OPEN  = 2'd2
    } guard_state_t;
endpackage

// File: rtl/kick_guard_fsm.sv
// Module: guard state machine for the register window.
// Tracks the two-key unlock sequence and drops back to shut on any other
// value written to an unlock register. Assumes at most one write per cycle.
module kick_guard_fsm
    import kick_lock_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter logic [DW-1:0] KEY_FIRST  = KEY_A,
    parameter logic [DW-1:0] KEY_SECOND = KEY_B
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_first,
    input  logic          wr_second,
    input  logic [DW-1:0] wdata,
    output logic          is_open
);
    guard_state_t state_q, state_d;
    logic first_ok, second_ok;

    // Key comparisons against the fixed values
    always_comb begin
        first_ok  = (wdata == KEY_FIRST);
        second_ok = (wdata == KEY_SECOND);
    end

    // Next-state decode of the unlock sequence
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GUARD_SHUT: begin
                if (wr_first && first_ok) state_d = GUARD_HALF;
            end
            GUARD_HALF: begin
                if (wr_second && second_ok)      state_d = GUARD_OPEN;
                else if (wr_first && first_ok)   state_d = GUARD_HALF;
                else if (wr_first || wr_second)  state_d = GUARD_SHUT;
            end
            GUARD_OPEN: begin
                if ((wr_first && !first_ok) || (wr_second && !second_ok))
                    state_d = GUARD_SHUT;
            end
            default: state_d = GUARD_SHUT;
        endcase
    end

    // State register with synchronous reset to shut
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GUARD_SHUT;
        else        state_q <= state_d;
    end

    assign is_open = (state_q == GUARD_OPEN);
endmodule

// File: rtl/guarded_regfile.sv
// Module: registers inside the guarded window.
// Holds the pad word, the masked clock-select word and a scratch array.
// Assumes the caller has already gated wr_en with the guard state.
module guarded_regfile
    import kick_lock_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W,
    parameter int unsigned NSCR = NUM_SCRATCH,
    parameter logic [DW-1:0] WMASK_CSEL = CSEL_MASK
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          rd_hit,
    output logic [DW-1:0] rd_val,
    output logic [DW-1:0] pad_q,
    output logic [DW-1:0] csel_q
);
    localparam int unsigned STEP = DW / 8;

    logic [DW-1:0] scr_q [NSCR];
    logic [NSCR-1:0] scr_sel;
    logic pad_sel, csel_sel;

    // Address decode of every register in the window
    always_comb begin
        pad_sel  = (addr == PAD_ADDR);
        csel_sel = (addr == CSEL_ADDR);
    end

    genvar g;
    generate
        for (g = 0; g < NSCR; g++) begin : g_scr
            // Decode and storage of one scratch word
            assign scr_sel[g] = (addr == AW'(SCR_BASE + AW'(g * STEP)));
            always_ff @(posedge clk) begin
                if (!rst_n)                  scr_q[g] <= '0;
                else if (wr_en && scr_sel[g]) scr_q[g] <= wdata;
            end
        end
    endgenerate

    // Pad word, fully writable
    always_ff @(posedge clk) begin
        if (!rst_n)                pad_q <= '0;
        else if (wr_en && pad_sel) pad_q <= wdata;
    end

    // Clock-select word, read-modify-write of the masked fields only
    always_ff @(posedge clk) begin
        if (!rst_n)                 csel_q <= '0;
        else if (wr_en && csel_sel) csel_q <= (csel_q & ~WMASK_CSEL) | (wdata & WMASK_CSEL);
    end

    // Read multiplexer over the window
    always_comb begin
        rd_hit = pad_sel | csel_sel | (|scr_sel);
        rd_val = '0;
        if (pad_sel)  rd_val = pad_q;
        if (csel_sel) rd_val = csel_q;
        for (int i = 0; i < NSCR; i++) begin
            if (scr_sel[i]) rd_val = scr_q[i];
        end
    end
endmodule

// File: rtl/kick_lock_regbank.sv
// Module: top of the key-guarded control register window.
// Decodes the bus, gates window writes with the guard state, registers
// read data and exports the pad and clock-select fields.
// Assumes single-cycle accesses and at most one write per cycle.
module kick_lock_regbank
    import kick_lock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pad_en,
    output logic              refclk_oe,
    output logic [SRC_W-1:0]  refclk_src,
    output logic              part_locked
);
    logic in_win, hit_k0, hit_k1, win_we, is_open;
    logic rf_hit;
    logic [DATA_W-1:0] rf_val, pad_q, csel_q, rd_next;

    // Bus address classification
    always_comb begin
        in_win = (bus_addr >= WIN_LO) && (bus_addr <= WIN_HI);
        hit_k0 = (bus_addr == UNLK0_ADDR);
        hit_k1 = (bus_addr == UNLK1_ADDR);
        win_we = bus_we && in_win && is_open;
    end

    kick_guard_fsm #(
        .DW(DATA_W), .KEY_FIRST(KEY_A), .KEY_SECOND(KEY_B)
    ) guard_i (
        .clk(clk), .rst_n(rst_n),
        .wr_first(bus_we && hit_k0), .wr_second(bus_we && hit_k1),
        .wdata(bus_wdata), .is_open(is_open)
    );

    guarded_regfile #(
        .AW(ADDR_W), .DW(DATA_W), .NSCR(NUM_SCRATCH), .WMASK_CSEL(CSEL_MASK)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(win_we), .addr(bus_addr),
        .wdata(bus_wdata), .rd_hit(rf_hit), .rd_val(rf_val),
        .pad_q(pad_q), .csel_q(csel_q)
    );

    // Read data selection across unlock registers and the window
    always_comb begin
        rd_next = '0;
        if (hit_k0 || hit_k1)  rd_next = {{(DATA_W-1){1'b0}}, is_open};
        else if (in_win && rf_hit) rd_next = rf_val;
    end

    // Registered read data, loaded on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_next;
    end

    assign pad_en      = pad_q[PAD_BIT];
    assign refclk_oe   = csel_q[OE_BIT];
    assign refclk_src  = csel_q[SRC_W-1:0];
    assign part_locked = !is_open;
endmodule

// File: rtl/kick_lock_regbank_chk.sv
// Module: property checker for the key-guarded register window.
// Observes only the top-level ports; attached to the top by bind.
module kick_lock_regbank_chk
    import kick_lock_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic              pad_en,
    input logic              refclk_oe,
    input logic [SRC_W-1:0]  refclk_src,
    input logic              part_locked
);
    // Only a write of the second key can open the window
    p_open_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(part_locked) |-> $past(bus_we && bus_addr == UNLK1_ADDR && bus_wdata == KEY_B));

    // Without a write to the second unlock register a locked window stays locked
    p_stay_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (part_locked && !(bus_we && bus_addr == UNLK1_ADDR)) |=> part_locked);

    // A non-key value in the first unlock register relocks an open window
    p_relock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!part_locked && bus_we && bus_addr == UNLK0_ADDR && bus_wdata != KEY_A) |=> part_locked);

    // Locked window leaves the pad and clock outputs untouched
    p_locked_outputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        part_locked |=> ($stable(pad_en) && $stable(refclk_oe) && $stable(refclk_src)));

    // Accepted pad write shows bit 24 on the next edge
    p_pad_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!part_locked && bus_we && bus_addr == PAD_ADDR) |=> (pad_en == $past(bus_wdata[PAD_BIT])));

    // Accepted clock-select write shows enable and source on the next edge
    p_csel_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!part_locked && bus_we && bus_addr == CSEL_ADDR) |=>
        (refclk_oe == $past(bus_wdata[OE_BIT]) && refclk_src == $past(bus_wdata[SRC_W-1:0])));
endmodule

bind kick_lock_regbank kick_lock_regbank_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .pad_en(pad_en), .refclk_oe(refclk_oe),
    .refclk_src(refclk_src), .part_locked(part_locked)
);

// File: tb/kick_lock_regbank_tb_top.sv
// Bench: directed sweeps over the key sequence, the masked clock-select
// word and the scratch array, with expected values computed locally.
module kick_lock_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        pad_en, refclk_oe, part_locked;
    logic [1:0]  refclk_src;

    int n_chk = 0;
    int n_err = 0;

    localparam logic [15:0] K0 = 16'h1008, K1 = 16'h100C;
    localparam logic [15:0] PADA = 16'h8100, CSA = 16'h8200, SCRA = 16'h8300;
    localparam logic [31:0] KA = 32'h68EF3490, KB = 32'hD172BC5A;

    kick_lock_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pad_en(pad_en), .refclk_oe(refclk_oe), .refclk_src(refclk_src),
        .part_locked(part_locked)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic open_win();
        wr(K0, KA);
        wr(K1, KB);
    endtask

    initial begin
        #400000;
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 locked", {31'b0, part_locked}, 32'd1);
        check("R1 outputs", {28'b0, pad_en, refclk_oe, refclk_src}, 32'd0);
        check("R1 rdata", bus_rdata, 32'd0);
        rd(PADA, v); check("R1 pad", v, 32'd0);
        rd(CSA, v);  check("R1 csel", v, 32'd0);
        for (int i = 0; i < 4; i++) begin
            rd(SCRA + 16'(4*i), v); check("R1 scratch", v, 32'd0);
        end

        // R5: locked writes dropped
        wr(PADA, 32'h0100_0000);
        check("R5 pad_en locked", {31'b0, pad_en}, 32'd0);
        rd(PADA, v); check("R5 pad read locked", v, 32'd0);

        // R3: wrong order
        wr(K1, KB);
        check("R3 order", {31'b0, part_locked}, 32'd1);
        // R3: corrupted first key, one nibble at a time
        for (int i = 0; i < 8; i++) begin
            wr(K0, KA ^ (32'h1 << (4*i)));
            wr(K1, KB);
            check("R3 bad first key", {31'b0, part_locked}, 32'd1);
        end
        // R3: corrupted second key
        for (int i = 0; i < 8; i++) begin
            wr(K0, KA);
            wr(K1, KB ^ (32'h8 << (4*i)));
            check("R3 bad second key", {31'b0, part_locked}, 32'd1);
        end
        // R3 and R9: interleaved bad write after first key
        wr(K0, KA);
        rd(K0, v); check("R9 half read", v, 32'd0);
        wr(K0, 32'h0);
        wr(K1, KB);
        check("R3 interleave", {31'b0, part_locked}, 32'd1);

        // R2: correct sequence
        open_win();
        check("R2 open", {31'b0, part_locked}, 32'd0);
        rd(K0, v); check("R9 open read k0", v, 32'd1);
        rd(K1, v); check("R9 open read k1", v, 32'd1);

        // R6: pad register
        wr(PADA, 32'h0100_0000);
        check("R6 pad_en set", {31'b0, pad_en}, 32'd1);
        wr(PADA, 32'hFEFF_FFFF);
        check("R6 pad_en clear", {31'b0, pad_en}, 32'd0);
        rd(PADA, v); check("R6 pad read", v, 32'hFEFF_FFFF);

        // R7: clock-select sweep over source, enable and filler
        for (int i = 0; i < 16; i++) begin
            logic [31:0] d;
            d = {23'b0, i[2], 6'b0, i[1:0]};
            if (i[3]) d = d | 32'hFFFF_FEFC;
            wr(CSA, d);
            check("R7 oe", {31'b0, refclk_oe}, {31'b0, i[2]});
            check("R7 src", {30'b0, refclk_src}, {30'b0, i[1:0]});
            rd(CSA, v); check("R7 readback", v, d & 32'h0000_0103);
        end

        // R8: scratch words
        for (int i = 0; i < 4; i++) wr(SCRA + 16'(4*i), (32'h1111_1111 * i) ^ 32'hA5A5_A5A5);
        for (int i = 0; i < 4; i++) begin
            rd(SCRA + 16'(4*i), v); check("R8 scratch", v, (32'h1111_1111 * i) ^ 32'hA5A5_A5A5);
        end

        // R10: unmapped reads and hold without strobe
        rd(16'h8004, v); check("R10 unmapped window", v, 32'd0);
        rd(16'h2000, v); check("R10 unmapped outside", v, 32'd0);
        rd(SCRA, v);
        @(negedge clk); bus_addr = PADA;
        @(negedge clk);
        check("R10 hold", bus_rdata, 32'hA5A5_A5A5);

        // R4: matching keys keep the window open
        wr(K0, KA);
        check("R4 key0 rewrite", {31'b0, part_locked}, 32'd0);
        wr(K1, KB);
        check("R4 key1 rewrite", {31'b0, part_locked}, 32'd0);
        // R4: all-ones relock
        wr(K0, 32'hFFFF_FFFF);
        check("R4 relock k0", {31'b0, part_locked}, 32'd1);
        rd(K1, v); check("R9 locked read", v, 32'd0);

        // R5: locked writes leave contents and outputs untouched
        wr(SCRA, 32'h0);
        rd(SCRA, v); check("R5 scratch kept", v, 32'hA5A5_A5A5);
        wr(CSA, 32'h0000_0000);
        check("R5 csel outputs kept", {30'b0, refclk_oe, refclk_src}, 32'h7);
        wr(16'h9FFC, 32'h1234_5678);
        rd(16'h9FFC, v); check("R5 top of window", v, 32'd0);

        // R4: relock through second register with arbitrary and all-ones values
        open_win();
        wr(K1, 32'h1234_5678);
        check("R4 relock k1", {31'b0, part_locked}, 32'd1);
        open_win();
        wr(K1, 32'hFFFF_FFFF);
        check("R4 relock k1 ones", {31'b0, part_locked}, 32'd1);

        // R1: reset mid-run clears everything
        open_win();
        wr(PADA, 32'h0100_0000);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 rerst locked", {31'b0, part_locked}, 32'd1);
        check("R1 rerst outputs", {28'b0, pad_en, refclk_oe, refclk_src}, 32'd0);
        rd(SCRA + 16'd12, v); check("R1 rerst scratch", v, 32'd0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule